// File: doc/BRIEF.md
# Modem Handshake Control and Status Change Detector

This block is the handshake side of a serial port. It drives two modem-control outputs (data-terminal-ready and request-to-send) from host-written control bits, and watches four modem-status inputs (clear-to-send, data-set-ready, carrier-detect and ring-indicate). Each status input is brought into the clock domain through a two-stage synchroniser. A sticky change flag is then kept for each input. The flags are combined into one interrupt line.

Clear-to-send, data-set-ready and carrier-detect flag a change on either edge. Ring-indicate flags only its trailing (high-to-low) edge. A loopback mode ties the control bits internally to the status path for self-test and holds the external control pins low. The host clears all change flags by reading the status word. All signals are active high.

Top module: `mdm_ctrl_top`

## Requirements
- R1: After reset, `dtr_o`, `rts_o` and `irq_o` are 0 and `sts_rdata` is 0.
- R2: A cycle with `ctl_wr`=1 loads `ctl_wdata` (bit0 terminal-ready, bit1 request-to-send, bit2 loop mode, bit3 interrupt enable). Outside loop mode, `dtr_o` and `rts_o` follow bits 0 and 1 from the next clock edge.
- R3: `sts_rdata[7:4]` show the synchronised levels of clear-to-send, data-set-ready, carrier-detect and ring-indicate, in that order from bit 4. A level change appears two clock edges after the input changes.
- R4: Any change of level, rising or falling, on clear-to-send, data-set-ready or carrier-detect sets its change flag (`sts_rdata` bit 0, 1 or 2 respectively) on the third clock edge after the input changes.
- R5: The ring-indicate change flag (`sts_rdata[3]`) is set only by a high-to-low transition. A low-to-high transition leaves it clear.
- R6: `irq_o` is 1 exactly when control bit 3 is set and at least one change flag is set. With bit 3 clear, flags still set but `irq_o` stays 0.
- R7: A cycle with `sts_rd`=1 clears all change flags, and with them `irq_o`, at the next edge. A change detected on that same edge sets its flag anyway.
- R8: Change flags are sticky: once set, they stay set until a read.
- R9: In loop mode both external control pins are held at 0. Data-set-ready and ring-indicate take the terminal-ready bit. Clear-to-send and carrier-detect take the request-to-send bit. The external status inputs are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_wr | input | 1 | Control write strobe |
| ctl_wdata | input | 4 | Control word: {int enable, loop, rts, dtr} |
| sts_rd | input | 1 | Status read strobe (clears change flags) |
| sts_rdata | output | 8 | {levels[3:0], change flags[3:0]} |
| cts_i | input | 1 | Clear-to-send input |
| dsr_i | input | 1 | Data-set-ready input |
| dcd_i | input | 1 | Carrier-detect input |
| ri_i | input | 1 | Ring-indicate input |
| dtr_o | output | 1 | Terminal-ready output |
| rts_o | output | 1 | Request-to-send output |
| irq_o | output | 1 | Modem-status interrupt |

## Verification
The hardest case to reach is a read strobe that lands on the same edge as a newly detected change. If the clear won, an event would be lost. The bench toggles an input and then counts the edges through the synchroniser and the edge detector. It asserts the read in the cycle just before the flag would set. It then expects the new flag to survive while an older flag is cleared. Loop mode is exercised by toggling the control bits and checking that the ring flag follows the internal trailing edge while external inputs are ignored.

// File: rtl/mdm_pkg.sv
package mdm_pkg;
  localparam int NSTAT   = 4;
  localparam int IDX_CTS = 0;
  localparam int IDX_DSR = 1;
  localparam int IDX_DCD = 2;
  localparam int IDX_RI  = 3;

  typedef struct packed {
    logic ie;
    logic loop;
    logic rts;
    logic dtr;
  } ctl_t;
endpackage

// File: rtl/mdm_sync.sv
module mdm_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] stg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg <= '0;
    end else begin
      stg[0] <= d_i;
      for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/mdm_delta.sv
module mdm_delta #(
  parameter int W         = 4,
  parameter int TRAIL_IDX = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl_i,
  input  logic         rd_i,
  output logic [W-1:0] delta_o
);
  logic [W-1:0] prev;
  logic [W-1:0] chg;

  for (genvar i = 0; i < W; i++) begin : g_edge
    if (i == TRAIL_IDX) begin : g_trail
      assign chg[i] = prev[i] & ~lvl_i[i];
    end else begin : g_any
      assign chg[i] = prev[i] ^ lvl_i[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev    <= '0;
      delta_o <= '0;
    end else begin
      prev    <= lvl_i;
      delta_o <= (rd_i ? '0 : delta_o) | chg;
    end
  end

  // R7
  rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_i && chg == '0) |=> delta_o == '0);

  // R8
  sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_i |=> (delta_o & $past(delta_o)) == $past(delta_o));

  // R5
  trail_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl_i[TRAIL_IDX] && !prev[TRAIL_IDX] && !delta_o[TRAIL_IDX]) |=> !delta_o[TRAIL_IDX]);
endmodule

// File: rtl/mdm_ctrl_top.sv
module mdm_ctrl_top
  import mdm_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ctl_wr,
  input  logic [3:0] ctl_wdata,
  input  logic       sts_rd,
  output logic [7:0] sts_rdata,
  input  logic       cts_i,
  input  logic       dsr_i,
  input  logic       dcd_i,
  input  logic       ri_i,
  output logic       dtr_o,
  output logic       rts_o,
  output logic       irq_o
);
  ctl_t             ctl;
  logic [NSTAT-1:0] st_raw;
  logic [NSTAT-1:0] st_lvl;
  logic [NSTAT-1:0] st_delta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ctl <= '0;
    else if (ctl_wr) ctl <= ctl_t'(ctl_wdata);
  end

  always_comb begin
    if (ctl.loop) begin
      st_raw[IDX_CTS] = ctl.rts;
      st_raw[IDX_DCD] = ctl.rts;
      st_raw[IDX_DSR] = ctl.dtr;
      st_raw[IDX_RI]  = ctl.dtr;
    end else begin
      st_raw[IDX_CTS] = cts_i;
      st_raw[IDX_DCD] = dcd_i;
      st_raw[IDX_DSR] = dsr_i;
      st_raw[IDX_RI]  = ri_i;
    end
  end

  mdm_sync #(.W(NSTAT), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(st_raw), .q_o(st_lvl)
  );

  mdm_delta #(.W(NSTAT), .TRAIL_IDX(IDX_RI)) u_delta (
    .clk(clk), .rst_n(rst_n), .lvl_i(st_lvl), .rd_i(sts_rd), .delta_o(st_delta)
  );

  assign dtr_o     = ctl.dtr & ~ctl.loop;
  assign rts_o     = ctl.rts & ~ctl.loop;
  assign irq_o     = ctl.ie & (|st_delta);
  assign sts_rdata = {st_lvl, st_delta};

  // R9
  loop_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.loop |-> (!dtr_o && !rts_o));

  // R6
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl.ie |-> !irq_o);

  // R2
  ctl_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr |=> (dtr_o == ($past(ctl_wdata[0]) && !$past(ctl_wdata[2]))) &&
               (rts_o == ($past(ctl_wdata[1]) && !$past(ctl_wdata[2]))));
endmodule

// File: tb/mdm_ctrl_top_bench.sv
module mdm_ctrl_top_bench;
  logic       clk = 0;
  logic       rst_n = 0;
  logic       ctl_wr = 0;
  logic [3:0] ctl_wdata = 0;
  logic       sts_rd = 0;
  logic [7:0] sts_rdata;
  logic       cts_i = 0, dsr_i = 0, dcd_i = 0, ri_i = 0;
  logic       dtr_o, rts_o, irq_o;
  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  mdm_ctrl_top u_mdm_ctrl_top (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
    .sts_rd(sts_rd), .sts_rdata(sts_rdata), .cts_i(cts_i), .dsr_i(dsr_i),
    .dcd_i(dcd_i), .ri_i(ri_i), .dtr_o(dtr_o), .rts_o(rts_o), .irq_o(irq_o)
  );

  task automatic check(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic edges(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr_ctl(input logic [3:0] v);
    @(negedge clk); ctl_wr = 1; ctl_wdata = v;
    @(negedge clk); ctl_wr = 0;
  endtask

  task automatic rd_sts(output logic [7:0] v);
    @(negedge clk); sts_rd = 1; v = sts_rdata;
    @(negedge clk); sts_rd = 0;
  endtask

  task automatic t_reset();
    check(dtr_o == 0 && rts_o == 0 && irq_o == 0, "R1 pins", {dtr_o, rts_o, irq_o}, 0);
    check(sts_rdata == 0, "R1 status", sts_rdata, 0);
  endtask

  task automatic t_ctl_write();
    wr_ctl(4'b0001);
    check(dtr_o == 1 && rts_o == 0, "R2 dtr only", {dtr_o, rts_o}, 8'h2);
    wr_ctl(4'b0010);
    check(dtr_o == 0 && rts_o == 1, "R2 rts only", {dtr_o, rts_o}, 8'h1);
    wr_ctl(4'b0000);
  endtask

  task automatic t_level_delta();
    logic [7:0] v;
    @(negedge clk); cts_i = 1;
    edges(2);
    check(sts_rdata == 8'h10, "R3 level after two edges, R4 flag not yet", sts_rdata, 8'h10);
    edges(1);
    check(sts_rdata == 8'h11, "R4 cts rise flag", sts_rdata, 8'h11);
    rd_sts(v);
    check(sts_rdata == 8'h10, "R7 read clears", sts_rdata, 8'h10);
    @(negedge clk); dsr_i = 1; dcd_i = 1;
    edges(4);
    check(sts_rdata == 8'h76, "R4 dsr dcd rise", sts_rdata, 8'h76);
    rd_sts(v);
    @(negedge clk); cts_i = 0; dcd_i = 0;
    edges(4);
    check(sts_rdata == 8'h25, "R4 cts dcd fall", sts_rdata, 8'h25);
    edges(6);
    check(sts_rdata == 8'h25, "R8 flags sticky", sts_rdata, 8'h25);
    rd_sts(v);
    @(negedge clk); dsr_i = 0;
    edges(4);
    rd_sts(v);
  endtask

  task automatic t_ri();
    logic [7:0] v;
    @(negedge clk); ri_i = 1;
    edges(4);
    check(sts_rdata == 8'h80, "R5 ri rise no flag", sts_rdata, 8'h80);
    @(negedge clk); ri_i = 0;
    edges(4);
    check(sts_rdata == 8'h08, "R5 ri fall flag", sts_rdata, 8'h08);
    rd_sts(v);
  endtask

  task automatic t_irq();
    logic [7:0] v;
    @(negedge clk); dcd_i = 1;
    edges(4);
    check(irq_o == 0 && sts_rdata[2] == 1, "R6 disabled irq", {irq_o, sts_rdata[2]}, 8'h1);
    wr_ctl(4'b1000);
    check(irq_o == 1, "R6 enabled irq", irq_o, 1);
    rd_sts(v);
    check(irq_o == 0, "R7 read drops irq", irq_o, 0);
    @(negedge clk); dcd_i = 0;
    edges(4);
    rd_sts(v);
    wr_ctl(4'b0000);
  endtask

  task automatic t_collision();
    logic [7:0] v;
    @(negedge clk); dsr_i = 1;
    edges(4);
    @(negedge clk); cts_i = 1;
    @(negedge clk);
    @(negedge clk); sts_rd = 1;
    @(negedge clk); sts_rd = 0;
    check(sts_rdata == 8'h31, "R7 new change survives read", sts_rdata, 8'h31);
    rd_sts(v);
    @(negedge clk); dsr_i = 0; cts_i = 0;
    edges(4);
    rd_sts(v);
  endtask

  task automatic t_loop();
    logic [7:0] v;
    wr_ctl(4'b0101);
    check(dtr_o == 0 && rts_o == 0, "R9 pins held low", {dtr_o, rts_o}, 0);
    @(negedge clk); cts_i = 1; dcd_i = 1;
    edges(4);
    check(sts_rdata[7:4] == 4'b1010, "R9 dtr to dsr ri, ext ignored", sts_rdata[7:4], 8'hA);
    rd_sts(v);
    wr_ctl(4'b0110);
    edges(3);
    check(sts_rdata == 8'h5F, "R9 loop swap, R5 ri trailing", sts_rdata, 8'h5F);
    rd_sts(v);
    wr_ctl(4'b0001);
    check(dtr_o == 1, "R2 loop exit pin", dtr_o, 1);
    edges(4);
    rd_sts(v);
  endtask

  initial begin
    edges(2);
    rst_n = 1;
    edges(1);
    t_reset();
    t_ctl_write();
    t_level_delta();
    t_ri();
    t_irq();
    t_collision();
    t_loop();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule